// File: doc/BRIEF.md
# Memory-Mapped Serial Port Controller

A word-addressed register slave that sits between a processor bus and a byte-wide serial character link. Incoming characters arrive on a valid/ready byte stream and are either queued in a receive FIFO or, when a receive transfer has been armed, handed straight to a DMA byte-write port. Outgoing characters leave on a second valid/ready byte stream, one per write of the data register. A single level-sensitive interrupt line combines three enable-gated sources.

Software programs the DMA engines through address and length registers. Writing a receive length first drains already-queued characters into the DMA port in arrival order, one per cycle, and leaves the remainder as a pending count that later characters consume. Writing a transmit length issues a one-cycle start pulse, with base and length, to the external transmit sequencer. Baud generation and framing live elsewhere.

Top module: `serial_port_regs`

## Requirements
- R1: The register index is address bits [11:2]: 0 identifier (reads ID_VALUE), 1 data, 2 FIFO occupancy, 3 interrupt enables, 4 transmit DMA address, 5 transmit DMA length, 6 receive DMA address, 7 receive DMA length, 8 FIFO depth (reads FIFO_DEPTH). Writes to indices 0, 2 and 8 change nothing.
- R2: Reading index 1 while the FIFO holds entries and no drain is running returns the oldest byte (zero-extended) and removes it.
- R3: Reading index 1 with an empty FIFO returns 0xFFFFFFFF and leaves the occupancy unchanged.
- R4: Writing index 1 presents bits [7:0] on the transmit stream; the byte is held until accepted, and a newer write replaces a byte not yet accepted.
- R5: The interrupt is high when enable bit 0 is set and the FIFO is non-empty, or enable bit 1 is set, or enable bit 2 is set and the pending receive count is zero.
- R6: With no pending receive count, rx_ready is high exactly while the FIFO has a free slot; a full FIFO accepts nothing.
- R7: While the pending receive count is non-zero, each accepted byte appears on the DMA write port at the receive address one cycle later, the address increments, the count decrements, and the FIFO is untouched.
- R8: Writing length L to index 7 with N bytes queued drains min(L,N) bytes in FIFO order to the DMA port, one per cycle, and sets the pending count to L-N when L>N, else 0. During a drain rx_ready is low and data reads return 0xFFFFFFFF without popping.
- R9: Writing index 6 loads the receive address and clears both the pending count and any drain.
- R10: Writing length L to index 5 pulses dma_tx_go for one cycle with the current transmit address and L, then advances that address by L; index 5 reads as zero.
- R11: An index above 8 reads zero, ignores a write and raises bad_access for the following cycle.
- R12: A data-register read and an accepted receive byte in the same cycle leave the occupancy unchanged and keep FIFO order.
- R13: Every read returns its data with rsp_valid high in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the register window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| bad_access | output | 1 | One-cycle strobe for an unmapped index |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit sink ready |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Receive acceptance |
| rx_data | input | 8 | Receive byte |
| dma_tx_go | output | 1 | Transmit DMA start pulse |
| dma_tx_base | output | 32 | Transmit DMA start address |
| dma_tx_len | output | 32 | Transmit DMA length |
| dma_wr_valid | output | 1 | Receive DMA byte write strobe |
| dma_wr_addr | output | 32 | Receive DMA byte address |
| dma_wr_data | output | 8 | Receive DMA byte |

## Verification
The FIFO can be pushed by the receive stream and popped by a data-register read in the same clock. The bench provokes this by raising rx_valid and issuing a data read in one cycle with two entries queued, then judges it by the returned byte, an unchanged occupancy and the order of the following reads. A drain started by a receive-length write is also overlapped with a data read, which must see the all-ones value while the DMA port receives the queued bytes in order.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;
   localparam int WORD_W = 32;
   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      IX_ID     = 4'd0,
      IX_DATA   = 4'd1,
      IX_COUNT  = 4'd2,
      IX_IRQEN  = 4'd3,
      IX_TXADDR = 4'd4,
      IX_TXLEN  = 4'd5,
      IX_RXADDR = 4'd6,
      IX_RXLEN  = 4'd7,
      IX_SIZE   = 4'd8
   } reg_ix_e;

   localparam int IRQ_FIFO_BIT = 0;
   localparam int IRQ_TX_BIT   = 1;
   localparam int IRQ_RX_BIT   = 2;
   localparam int IRQ_W        = 3;

   localparam logic [WORD_W-1:0] EMPTY_READ = '1;
endpackage

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [CNT_W-1:0]  count
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  rd_ptr;
   logic [PTR_W-1:0]  rd_next;
   logic [PTR_W-1:0]  wr_slot;

   if (DEPTH < 2) begin : g_bad_depth
      $error("serial_rx_fifo: DEPTH must be at least 2");
   end

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign rd_next = rd_ptr + PTR_W'(1);
      assign wr_slot = rd_ptr + count[PTR_W-1:0];
   end else begin : g_modulo
      logic [CNT_W:0] slot_sum;
      assign slot_sum = (CNT_W+1)'(rd_ptr) + (CNT_W+1)'(count);
      assign wr_slot  = (slot_sum >= (CNT_W+1)'(DEPTH))
                        ? PTR_W'(slot_sum - (CNT_W+1)'(DEPTH))
                        : PTR_W'(slot_sum);
      assign rd_next  = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
   end

   assign head = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_slot] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (pop) rd_ptr <= rd_next;
         case ({push, pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      push && !pop |-> count != CNT_W'(DEPTH));
   p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> count != '0);
   p_count_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      push && pop |=> $stable(count));
endmodule

// File: rtl/serial_irq.sv
module serial_irq
   import serial_port_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IRQ_W-1:0] enable,
   input  logic             fifo_nonempty,
   input  logic             rx_pend_zero,
   output logic             irq
);
   logic [IRQ_W-1:0] term;

   always_comb begin
      term = '0;
      term[IRQ_FIFO_BIT] = enable[IRQ_FIFO_BIT] && fifo_nonempty;
      term[IRQ_TX_BIT]   = enable[IRQ_TX_BIT];
      term[IRQ_RX_BIT]   = enable[IRQ_RX_BIT] && rx_pend_zero;
   end

   assign irq = |term;

   p_irq_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
      enable[IRQ_TX_BIT] |-> irq);
   p_irq_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      enable == '0 |-> !irq);
endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
   import serial_port_pkg::*;
#(
   parameter int          FIFO_DEPTH = 16,
   parameter int          ADDR_W     = 12,
   parameter logic [31:0] ID_VALUE   = 32'h5E71_0001,
   localparam int IX_W  = ADDR_W - 2,
   localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   output logic              bad_access,
   output logic              irq,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [7:0]        tx_data,
   input  logic              rx_valid,
   output logic              rx_ready,
   input  logic [7:0]        rx_data,
   output logic              dma_tx_go,
   output logic [31:0]       dma_tx_base,
   output logic [31:0]       dma_tx_len,
   output logic              dma_wr_valid,
   output logic [31:0]       dma_wr_addr,
   output logic [7:0]        dma_wr_data
);
   if (ADDR_W != 12) begin : g_bad_addr
      $error("serial_port_regs: the register window decodes exactly 12 address bits");
   end
   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("serial_port_regs: FIFO_DEPTH must be at least 2");
   end

   // ---------------- decode ----------------
   logic [IX_W-1:0] idx;
   logic            unused_addr_lsb;
   logic            mapped;
   logic            rd_req, wr_req;

   assign idx             = req_addr[ADDR_W-1:2];
   assign unused_addr_lsb = ^req_addr[1:0];
   assign mapped          = idx <= IX_W'(IX_SIZE);
   assign rd_req          = req_valid && !req_write;
   assign wr_req          = req_valid && req_write;

   function automatic logic hit(input logic [IX_W-1:0] i, input reg_ix_e r);
      return i == IX_W'(r);
   endfunction

   logic data_wr, irqen_wr, txaddr_wr, txlen_wr, rxaddr_wr, rxlen_wr, data_rd;
   assign data_wr   = wr_req && hit(idx, IX_DATA);
   assign irqen_wr  = wr_req && hit(idx, IX_IRQEN);
   assign txaddr_wr = wr_req && hit(idx, IX_TXADDR);
   assign txlen_wr  = wr_req && hit(idx, IX_TXLEN);
   assign rxaddr_wr = wr_req && hit(idx, IX_RXADDR);
   assign rxlen_wr  = wr_req && hit(idx, IX_RXLEN);
   assign data_rd   = rd_req && hit(idx, IX_DATA);

   // ---------------- state ----------------
   logic [IRQ_W-1:0]  irq_en;
   logic [31:0]       tx_addr_q;
   logic [31:0]       rx_addr_q;
   logic [31:0]       rx_pend_q;
   logic [CNT_W-1:0]  drain_q;
   logic [CNT_W-1:0]  occ;
   logic [BYTE_W-1:0] fifo_head;

   logic draining, fifo_full, rx_hold, rx_fire, rx_to_dma, fifo_push, cpu_pop, fifo_pop;

   assign draining  = drain_q != '0;
   assign fifo_full = occ == CNT_W'(FIFO_DEPTH);
   assign rx_hold   = rxaddr_wr || rxlen_wr;
   assign rx_ready  = !rx_hold && !draining && ((rx_pend_q != '0) || !fifo_full);
   assign rx_fire   = rx_valid && rx_ready;
   assign rx_to_dma = rx_fire && (rx_pend_q != '0);
   assign fifo_push = rx_fire && (rx_pend_q == '0);
   assign cpu_pop   = data_rd && (occ != '0) && !draining;
   assign fifo_pop  = cpu_pop || draining;

   serial_rx_fifo #(
      .DEPTH  (FIFO_DEPTH),
      .DATA_W (BYTE_W)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (fifo_push),
      .push_data (rx_data),
      .pop       (fifo_pop),
      .head      (fifo_head),
      .count     (occ)
   );

   serial_irq u_irq (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable        (irq_en),
      .fifo_nonempty (occ != '0),
      .rx_pend_zero  (rx_pend_q == '0),
      .irq           (irq)
   );

   // ---------------- read path ----------------
   logic [31:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (mapped) begin
         case (reg_ix_e'(idx[3:0]))
            IX_ID:     rd_mux = ID_VALUE;
            IX_DATA:   rd_mux = cpu_pop ? 32'(fifo_head) : EMPTY_READ;
            IX_COUNT:  rd_mux = 32'(occ);
            IX_IRQEN:  rd_mux = 32'(irq_en);
            IX_TXADDR: rd_mux = tx_addr_q;
            IX_TXLEN:  rd_mux = '0;
            IX_RXADDR: rd_mux = rx_addr_q;
            IX_RXLEN:  rd_mux = rx_pend_q;
            IX_SIZE:   rd_mux = 32'(FIFO_DEPTH);
            default:   rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_rdata  <= '0;
         bad_access <= 1'b0;
      end else begin
         rsp_valid  <= rd_req;
         rsp_rdata  <= rd_req ? rd_mux : '0;
         bad_access <= req_valid && !mapped;
      end
   end

   // ---------------- control registers and transmit ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_en      <= '0;
         tx_valid    <= 1'b0;
         tx_data     <= '0;
         tx_addr_q   <= '0;
         dma_tx_go   <= 1'b0;
         dma_tx_base <= '0;
         dma_tx_len  <= '0;
      end else begin
         if (irqen_wr) irq_en <= req_wdata[IRQ_W-1:0];
         if (data_wr) begin
            tx_valid <= 1'b1;
            tx_data  <= req_wdata[BYTE_W-1:0];
         end else if (tx_ready) begin
            tx_valid <= 1'b0;
         end
         dma_tx_go <= txlen_wr;
         if (txaddr_wr) begin
            tx_addr_q <= req_wdata;
         end else if (txlen_wr) begin
            dma_tx_base <= tx_addr_q;
            dma_tx_len  <= req_wdata;
            tx_addr_q   <= tx_addr_q + req_wdata;
         end
      end
   end

   // ---------------- receive DMA ----------------
   logic [31:0] occ_w;
   assign occ_w = 32'(occ);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_addr_q    <= '0;
         rx_pend_q    <= '0;
         drain_q      <= '0;
         dma_wr_valid <= 1'b0;
         dma_wr_addr  <= '0;
         dma_wr_data  <= '0;
      end else begin
         dma_wr_valid <= draining || rx_to_dma;
         if (draining || rx_to_dma) begin
            dma_wr_addr <= rx_addr_q;
            dma_wr_data <= draining ? fifo_head : rx_data;
         end
         if (rxaddr_wr) begin
            rx_addr_q <= req_wdata;
            rx_pend_q <= '0;
            drain_q   <= '0;
         end else if (rxlen_wr) begin
            if (req_wdata > occ_w) begin
               rx_pend_q <= req_wdata - occ_w;
               drain_q   <= occ;
            end else begin
               rx_pend_q <= '0;
               drain_q   <= CNT_W'(req_wdata);
            end
         end else begin
            if (draining || rx_to_dma) rx_addr_q <= rx_addr_q + 32'd1;
            if (draining)  drain_q   <= drain_q - CNT_W'(1);
            if (rx_to_dma) rx_pend_q <= rx_pend_q - 32'd1;
         end
      end
   end

   // ---------------- assertions ----------------
   p_rsp_follows_r13: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rsp_valid);
   p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (idx > IX_W'(IX_SIZE)) |=> bad_access);
   p_dma_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_ready && (rx_pend_q != '0) |=> dma_wr_valid && (dma_wr_data == $past(rx_data)));
   p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready && !data_wr |=> tx_valid && $stable(tx_data));
   p_drain_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      draining |-> !rx_ready);
endmodule

// File: tb/sim_serial_port_regs.sv
module sim_serial_port_regs;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;
   localparam logic [31:0] IDV = 32'h5E71_0001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, bad_access, irq;
   logic [31:0] rsp_rdata;
   logic        tx_valid, tx_ready = 1'b1;
   logic [7:0]  tx_data;
   logic        rx_valid = 1'b0, rx_ready;
   logic [7:0]  rx_data = '0;
   logic        dma_tx_go, dma_wr_valid;
   logic [31:0] dma_tx_base, dma_tx_len, dma_wr_addr;
   logic [7:0]  dma_wr_data;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   logic [7:0]  exp_tx[$];
   logic [39:0] exp_dma[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_port_regs #(.FIFO_DEPTH(DEPTH), .ID_VALUE(IDV)) u0 (
      .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata,
      .rsp_valid, .rsp_rdata, .bad_access, .irq,
      .tx_valid, .tx_ready, .tx_data, .rx_valid, .rx_ready, .rx_data,
      .dma_tx_go, .dma_tx_base, .dma_tx_len,
      .dma_wr_valid, .dma_wr_addr, .dma_wr_data
   );

   task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wr(input int ix, input logic [31:0] d);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 12'(ix * 4); req_wdata = d;
      step();
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(input int ix, output logic [31:0] d);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 12'(ix * 4);
      step();
      d = rsp_rdata;
      check("R13 rsp_valid", 40'(rsp_valid), 40'd1);
      req_valid = 1'b0;
   endtask

   task automatic rd_chk(input string req, input int ix, input logic [31:0] exp);
      logic [31:0] d;
      rd(ix, d);
      check(req, 40'(d), 40'(exp));
   endtask

   task automatic rx_send(input logic [7:0] b);
      rx_valid = 1'b1; rx_data = b;
      while (!rx_ready) step();
      step();
      rx_valid = 1'b0;
   endtask

   // scoreboard monitors, sampled mid-cycle
   always @(negedge clk) begin
      if (rst_n && tx_valid && tx_ready) begin
         if (exp_tx.size() == 0) check("R4 unexpected tx byte", 40'(tx_data), 40'hFF_FFFF_FFFF);
         else check("R4 tx byte", 40'(tx_data), 40'(exp_tx.pop_front()));
      end
      if (rst_n && dma_wr_valid) begin
         if (exp_dma.size() == 0) check("R7/R8 unexpected dma write", {dma_wr_addr, dma_wr_data}, 40'hFF_FFFF_FFFF);
         else check("R7/R8 dma write", {dma_wr_addr, dma_wr_data}, exp_dma.pop_front());
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state
      check("R5 reset irq", 40'(irq), 40'd0);
      check("R4 reset tx_valid", 40'(tx_valid), 40'd0);
      check("R6 reset rx_ready", 40'(rx_ready), 40'd1);
      rd_chk("R1 id", 0, IDV);
      rd_chk("R1 size", 8, DEPTH);
      rd_chk("R1 count", 2, 0);

      // writes to read-only indices ignored
      wr(0, 32'h1234_5678); wr(2, 32'd9); wr(8, 32'd3);
      rd_chk("R1 id after write", 0, IDV);
      rd_chk("R1 count after write", 2, 0);
      rd_chk("R1 size after write", 8, DEPTH);

      // empty data read
      rd_chk("R3 empty read", 1, 32'hFFFF_FFFF);
      rd_chk("R3 count unchanged", 2, 0);

      // transmit
      exp_tx.push_back(8'hA5);
      wr(1, 32'h0000_01A5);
      step();
      tx_ready = 1'b0;
      wr(1, 32'h33); wr(1, 32'h44);
      step();
      check("R4 held byte", 40'(tx_data), 40'h44);
      exp_tx.push_back(8'h44);
      tx_ready = 1'b1;
      step(); step();
      check("R4 tx drained", 40'(exp_tx.size()), 40'd0);

      // receive into FIFO, order
      wr(3, 32'd1);
      rx_send(8'h11); rx_send(8'h22); rx_send(8'h33);
      rd_chk("R2 count 3", 2, 3);
      check("R5 fifo irq", 40'(irq), 40'd1);
      rd_chk("R2 oldest", 1, 32'h11);

      // simultaneous pop and push
      rx_valid = 1'b1; rx_data = 8'h44;
      req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h004;
      step();
      check("R12 popped byte", 40'(rsp_rdata), 40'h22);
      rx_valid = 1'b0; req_valid = 1'b0;
      rd_chk("R12 count unchanged", 2, 2);
      rd_chk("R12 order a", 1, 32'h33);
      rd_chk("R12 order b", 1, 32'h44);
      check("R5 fifo irq off", 40'(irq), 40'd0);

      // fill
      for (int i = 0; i < DEPTH; i++) rx_send(8'(8'h80 + i));
      check("R6 full blocks", 40'(rx_ready), 40'd0);
      rd_chk("R6 count full", 2, DEPTH);

      // interrupt terms
      wr(3, 32'd2); wr(2, 0);
      check("R5 tx term", 40'(irq), 40'd1);
      wr(3, 32'd0);
      check("R5 none", 40'(irq), 40'd0);

      // drain on receive start
      wr(6, 32'h1000);
      for (int i = 0; i < DEPTH; i++) exp_dma.push_back({32'h1000 + 32'(i), 8'(8'h80 + i)});
      wr(7, 32'd20);
      check("R8 drain blocks rx", 40'(rx_ready), 40'd0);
      rd_chk("R8 read during drain", 1, 32'hFFFF_FFFF);
      repeat (DEPTH + 2) step();
      rd_chk("R8 count drained", 2, 0);
      rd_chk("R8 pending", 7, 4);
      rd_chk("R8 address", 6, 32'h1010);
      wr(3, 32'd4);
      check("R5 rx term pending", 40'(irq), 40'd0);

      // direct DMA receive
      for (int i = 0; i < 4; i++) exp_dma.push_back({32'h1010 + 32'(i), 8'(8'h5A + i)});
      for (int i = 0; i < 4; i++) rx_send(8'(8'h5A + i));
      step();
      rd_chk("R7 pending done", 7, 0);
      rd_chk("R7 fifo untouched", 2, 0);
      rd_chk("R7 address", 6, 32'h1014);
      check("R5 rx term idle", 40'(irq), 40'd1);
      check("R7 dma all seen", 40'(exp_dma.size()), 40'd0);

      // address write cancels
      wr(7, 32'd5);
      rd_chk("R9 pending armed", 7, 5);
      wr(6, 32'h2000);
      rd_chk("R9 pending cleared", 7, 0);
      rd_chk("R9 address", 6, 32'h2000);

      // transmit DMA
      wr(4, 32'h3000);
      wr(5, 32'd7);
      check("R10 go", 40'(dma_tx_go), 40'd1);
      check("R10 base", 40'(dma_tx_base), 40'h3000);
      check("R10 len", 40'(dma_tx_len), 40'd7);
      step();
      check("R10 go one cycle", 40'(dma_tx_go), 40'd0);
      rd_chk("R10 address advanced", 4, 32'h3007);
      rd_chk("R10 length reads zero", 5, 0);

      // unmapped
      rd(9, d);
      check("R11 read zero", 40'(d), 40'd0);
      check("R11 error strobe", 40'(bad_access), 40'd1);
      step();
      check("R11 strobe ends", 40'(bad_access), 40'd0);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 12'hFFC; req_wdata = 32'h0;
      step();
      req_valid = 1'b0; req_write = 1'b0;
      check("R11 write strobe", 40'(bad_access), 40'd1);
      rd_chk("R11 write ignored", 3, 4);

      step(); step();
      check("R4 no stray tx", 40'(exp_tx.size()), 40'd0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule